// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block keeps the 64-bit compare value of the supervisor-level timer and turns it into the supervisor timer-pending level. On every clock edge it checks the free-running 64-bit time input against the stored value, treating both as unsigned. It registers the result, so the pending level follows time and compare changes one cycle later. The time counter is outside the block and reaches it through an input port.

Software reaches the compare value through a small CSR access port with a one-cycle strobe. With a 32-bit data path, address 0x14D maps to the low word and address 0x15D maps to the high word. With a 64-bit data path, 0x14D maps to the whole value and 0x15D is flagged as an invalid address. The access port has no back-pressure. A strobed access always completes in its own cycle. Read data and the hit and invalid flags are combinational. A write takes effect at the clock edge that samples it.

A machine-level enable input selects the source of the pending output. When the enable is high, the registered compare result drives the output and the software pending input is ignored. When the enable is low, the software pending input passes straight through. Privilege checks, exceptions, delegation and interrupt priority belong to the surrounding core.

Top module: `stc_unit`

## Requirements
- R1: After reset the compare value is all ones, a read of 0x14D returns all ones, and with the enable high and time zero the pending output is 0.
- R2: With XLEN=32, address 0x14D reads and writes compare bits 31:0 and address 0x15D reads and writes bits 63:32. A write to one half leaves the other half unchanged.
- R3: With XLEN=64, address 0x14D reads and writes all 64 bits. An access to 0x15D raises `csr_bad_addr`, reads as 0 and leaves the compare value unchanged.
- R4: A strobed access to any other address gives `csr_hit`=0 and read data 0, and its write changes nothing. A strobed access to a mapped address gives `csr_hit`=1.
- R5: With the enable high, `stip_o` after a clock edge equals (time >= compare), unsigned over 64 bits, using the time and compare values present at that edge. A change therefore shows one cycle later.
- R6: Once pending, the output stays 1 until the compare value exceeds time. Writing a larger compare value clears it one cycle after the write edge. Writing a value at or below time sets it again.
- R7: With the enable low, `stip_o` equals `sw_stip_i` in the same cycle, whatever the compare result is.
- R8: With the enable high, `sw_stip_i` has no effect on `stip_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| time_i | input | 64 | Current time value |
| stce_i | input | 1 | Enable of the compare path (machine environment config) |
| sw_stip_i | input | 1 | Software-owned pending bit, used while the enable is low |
| csr_valid | input | 1 | Access strobe, one cycle per access |
| csr_we | input | 1 | Write when 1, read when 0 |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, 0 when not hit |
| csr_hit | output | 1 | Access targets a mapped address |
| csr_bad_addr | output | 1 | Access to the high-word address in 64-bit mode |
| stip_o | output | 1 | Supervisor timer pending level |

## Verification
Read data and the address flags are due in the same cycle as the strobe. The bench samples them 1 ns after it drives the access, before any clock edge. A write lands on the next rising edge, and the compare result it causes is due one edge after that. The bench therefore changes time only at a falling edge and checks `stip_o` at the following falling edge. It also checks once just after the change, to confirm that the old level still holds. The software-pending path is combinational, so the bench checks it 1 ns after each change of its input.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam logic [11:0] CMP_LO_ADDR = 12'h14D;
  localparam logic [11:0] CMP_HI_ADDR = 12'h15D;
  localparam int unsigned TICK_W = 64;
  typedef logic [TICK_W-1:0] tick_t;
endpackage

// File: rtl/stc_cmp_regs.sv
module stc_cmp_regs
  import stc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_we,
  input  logic [11:0]     acc_addr,
  input  logic [XLEN-1:0] acc_wdata,
  output logic [XLEN-1:0] acc_rdata,
  output logic            acc_hit,
  output logic            acc_bad,
  output tick_t           cmp_val
);
  localparam tick_t RESET_VAL = '1;
  localparam int unsigned HALF_W = TICK_W / 2;

  tick_t cmp_q;
  tick_t cmp_d;

  generate
    if (XLEN == 32) begin : g_split
      logic sel_lo;
      logic sel_hi;
      assign sel_lo = acc_valid && (acc_addr == CMP_LO_ADDR);
      assign sel_hi = acc_valid && (acc_addr == CMP_HI_ADDR);
      assign acc_hit = sel_lo || sel_hi;
      assign acc_bad = 1'b0;

      always_comb begin
        acc_rdata = '0;
        if (sel_lo) acc_rdata = cmp_q[HALF_W-1:0];
        if (sel_hi) acc_rdata = cmp_q[TICK_W-1:HALF_W];
      end

      always_comb begin
        cmp_d = cmp_q;
        if (sel_lo && acc_we) cmp_d[HALF_W-1:0] = acc_wdata;
        if (sel_hi && acc_we) cmp_d[TICK_W-1:HALF_W] = acc_wdata;
      end

      // R2
      hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_hi && acc_we) |=> $stable(cmp_q[HALF_W-1:0]));
    end else begin : g_full
      logic sel_full;
      assign sel_full = acc_valid && (acc_addr == CMP_LO_ADDR);
      assign acc_hit = sel_full;
      assign acc_bad = acc_valid && (acc_addr == CMP_HI_ADDR);
      assign acc_rdata = sel_full ? cmp_q : '0;

      always_comb begin
        cmp_d = cmp_q;
        if (sel_full && acc_we) cmp_d = acc_wdata;
      end

      // R3
      bad_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_bad && acc_we) |=> $stable(cmp_q));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= RESET_VAL;
    else        cmp_q <= cmp_d;
  end

  assign cmp_val = cmp_q;

  // R4
  miss_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit) |=> $stable(cmp_q));
endmodule

// File: rtl/stc_pend_cmp.sv
module stc_pend_cmp
  import stc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  tick_t time_i,
  input  tick_t cmp_val,
  output logic  pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (time_i >= cmp_val);
  end

  // R5
  due_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_i >= cmp_val) |=> pend_q);

  // R6
  not_due_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_val > time_i) |=> !pend_q);
endmodule

// File: rtl/stc_unit.sv
module stc_unit
  import stc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [63:0]     time_i,
  input  logic            stce_i,
  input  logic            sw_stip_i,
  input  logic            csr_valid,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_hit,
  output logic            csr_bad_addr,
  output logic            stip_o
);
  tick_t cmp_val;
  logic  cmp_pend;

  stc_cmp_regs #(.XLEN(XLEN)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (csr_valid),
    .acc_we    (csr_we),
    .acc_addr  (csr_addr),
    .acc_wdata (csr_wdata),
    .acc_rdata (csr_rdata),
    .acc_hit   (csr_hit),
    .acc_bad   (csr_bad_addr),
    .cmp_val   (cmp_val)
  );

  stc_pend_cmp i_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .time_i  (time_i),
    .cmp_val (cmp_val),
    .pend_q  (cmp_pend)
  );

  assign stip_o = stce_i ? cmp_pend : sw_stip_i;

  // R8
  enabled_ignores_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stce_i && $stable(stce_i) && !$stable(sw_stip_i)) |-> (stip_o == cmp_pend));
endmodule

// File: tb/test_stc_unit.sv
`timescale 1ns/1ps
module test_stc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_i = '0;
  logic        stce = 1'b1;
  logic        sw_stip = 1'b0;

  logic        a_v = 1'b0, a_we = 1'b0;
  logic [11:0] a_addr = '0;
  logic [31:0] a_wd = '0;
  logic [31:0] a_rd;
  logic        a_hit, a_bad, a_stip;

  logic        b_v = 1'b0, b_we = 1'b0;
  logic [11:0] b_addr = '0;
  logic [63:0] b_wd = '0;
  logic [63:0] b_rd;
  logic        b_hit, b_bad, b_stip;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  stc_unit #(.XLEN(32)) i_stc_unit (
    .clk(clk), .rst_n(rst_n), .time_i(time_i), .stce_i(stce), .sw_stip_i(sw_stip),
    .csr_valid(a_v), .csr_we(a_we), .csr_addr(a_addr), .csr_wdata(a_wd),
    .csr_rdata(a_rd), .csr_hit(a_hit), .csr_bad_addr(a_bad), .stip_o(a_stip));

  stc_unit #(.XLEN(64)) i_stc_unit_x64 (
    .clk(clk), .rst_n(rst_n), .time_i(time_i), .stce_i(stce), .sw_stip_i(sw_stip),
    .csr_valid(b_v), .csr_we(b_we), .csr_addr(b_addr), .csr_wdata(b_wd),
    .csr_rdata(b_rd), .csr_hit(b_hit), .csr_bad_addr(b_bad), .stip_o(b_stip));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr32(input logic [11:0] ad, input logic [31:0] d);
    @(negedge clk); a_v = 1'b1; a_we = 1'b1; a_addr = ad; a_wd = d;
    @(negedge clk); a_v = 1'b0; a_we = 1'b0;
  endtask

  task automatic wr64(input logic [11:0] ad, input logic [63:0] d);
    @(negedge clk); b_v = 1'b1; b_we = 1'b1; b_addr = ad; b_wd = d;
    @(negedge clk); b_v = 1'b0; b_we = 1'b0;
  endtask

  task automatic rd32(input logic [11:0] ad, output logic [31:0] d, output logic h);
    a_v = 1'b1; a_we = 1'b0; a_addr = ad; #1; d = a_rd; h = a_hit; a_v = 1'b0;
  endtask

  task automatic rd64(input logic [11:0] ad, output logic [63:0] d, output logic h,
                      output logic bad);
    b_v = 1'b1; b_we = 1'b0; b_addr = ad; #1; d = b_rd; h = b_hit; bad = b_bad; b_v = 1'b0;
  endtask

  task automatic set_cmp(input logic [63:0] v);
    wr32(12'h14D, v[31:0]);
    wr32(12'h15D, v[63:32]);
    wr64(12'h14D, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r32;
    logic [63:0] r64;
    logic h, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    rd32(12'h14D, r32, h); chk("R1 lo", r32, 32'hFFFF_FFFF);
    rd64(12'h14D, r64, h, bad); chk("R1 full", r64, '1);
    chk("R1 stip32", a_stip, 0); chk("R1 stip64", b_stip, 0);

    // R5 sweep over small and wrapped values
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 3; c++)
          for (int d = 0; d < 4; d++) begin
            logic [31:0] hv [3];
            logic [63:0] cv, tv;
            hv[0] = 32'h0; hv[1] = 32'h1; hv[2] = 32'hFFFF_FFFF;
            cv = {hv[a], 32'(b)};
            tv = {hv[c], 32'(d)};
            set_cmp(cv);
            time_i = tv;
            @(negedge clk);
            chk("R5 sweep32", a_stip, (tv >= cv));
            chk("R5 sweep64", b_stip, (tv >= cv));
          end

    // R5 one-cycle latency
    set_cmp(64'd100); time_i = 64'd99;
    @(negedge clk);
    chk("R5 before32", a_stip, 0);
    time_i = 64'd100; #1;
    chk("R5 hold32", a_stip, 0); chk("R5 hold64", b_stip, 0);
    @(negedge clk);
    chk("R5 due32", a_stip, 1); chk("R5 due64", b_stip, 1);

    // R6 clear by larger compare, set again by smaller
    time_i = 64'd200; set_cmp(64'd100); @(negedge clk);
    chk("R6 pend32", a_stip, 1);
    wr32(12'h14D, 32'd300);
    chk("R6 still32", a_stip, 1);
    @(negedge clk);
    chk("R6 cleared32", a_stip, 0);
    wr64(12'h14D, 64'd300); @(negedge clk);
    chk("R6 cleared64", b_stip, 0);
    wr32(12'h14D, 32'd150); @(negedge clk);
    chk("R6 reset32", a_stip, 1);

    // R7 software bit passes through while disabled
    set_cmp(64'd100); time_i = 64'd200; @(negedge clk);
    stce = 1'b0; sw_stip = 1'b0; #1;
    chk("R7 sw0 32", a_stip, 0); chk("R7 sw0 64", b_stip, 0);
    sw_stip = 1'b1; #1;
    chk("R7 sw1 32", a_stip, 1); chk("R7 sw1 64", b_stip, 1);

    // R8 software bit ignored while enabled
    stce = 1'b1; set_cmp(64'd500); @(negedge clk);
    sw_stip = 1'b1; #1;
    chk("R8 sw1 32", a_stip, 0); chk("R8 sw1 64", b_stip, 0);
    sw_stip = 1'b0;

    // R2 halves are independent
    wr32(12'h14D, 32'h1234_5678); wr32(12'h15D, 32'hABCD_EF01);
    @(negedge clk);
    rd32(12'h14D, r32, h); chk("R2 lo", r32, 32'h1234_5678); chk("R4 hit lo", h, 1);
    rd32(12'h15D, r32, h); chk("R2 hi", r32, 32'hABCD_EF01); chk("R4 hit hi", h, 1);
    wr32(12'h14D, 32'h0BAD_F00D); @(negedge clk);
    rd32(12'h15D, r32, h); chk("R2 hi kept", r32, 32'hABCD_EF01);
    wr32(12'h15D, 32'h0000_0007); @(negedge clk);
    rd32(12'h14D, r32, h); chk("R2 lo kept", r32, 32'h0BAD_F00D);

    // R4 unmapped address
    wr32(12'h14E, 32'h5555_5555); @(negedge clk);
    rd32(12'h14E, r32, h); chk("R4 miss hit", h, 0); chk("R4 miss data", r32, 0);
    rd32(12'h14D, r32, h); chk("R4 lo unchanged", r32, 32'h0BAD_F00D);
    rd32(12'h15D, r32, h); chk("R4 hi unchanged", r32, 32'h0000_0007);

    // R3 64-bit map
    wr64(12'h14D, 64'hDEAD_BEEF_0123_4567); @(negedge clk);
    rd64(12'h14D, r64, h, bad); chk("R3 full", r64, 64'hDEAD_BEEF_0123_4567);
    chk("R3 no bad", bad, 0);
    wr64(12'h15D, 64'h1111_2222_3333_4444); @(negedge clk);
    rd64(12'h15D, r64, h, bad); chk("R3 bad flag", bad, 1); chk("R3 bad data", r64, 0);
    chk("R3 bad hit", h, 0);
    rd64(12'h14D, r64, h, bad); chk("R3 unchanged", r64, 64'hDEAD_BEEF_0123_4567);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule